// File: doc/BRIEF.md
# Short-Transfer Report Queue

This block sits next to a DMA submission queue and keeps a small first-in, first-out log of transfers that ended before their programmed length. A data source can end a transfer early, for example on an early end-of-packet. If that transfer was submitted with its report request flag set (flag bit 2 of the submission), the block stores one record. The record holds the transfer's 5-bit ID and the number of bytes that were actually moved. Every transfer end also sets a sticky completion bit for its ID, whether the end was early or not.

Software reads the records out through a register pair. It reads the byte count of the oldest record at offset 0x44C, and then the ID at offset 0x450. The ID read removes the record from the queue. The completion register at 0x428 holds the per-ID completion bits. Bit 31 of that register is a summary flag that stays set while any record is still unread, and bit 30 is a sticky overflow flag. When the queue is full, a new record is dropped and the overflow flag is set.

Reads use a one-cycle pipeline: the data for a read strobed on one clock edge appears on `rdData` after that edge and stays there for one cycle.

Top module: `xfer_short_report`

## Requirements
- R1: After reset the queue is empty, all completion bits and the overflow flag are 0, and `rdData` is 0.
- R2: A record is stored only when `endValid`, `endPartial` and `endReport` are all high in the same cycle. An end that is not early, or an early end without the report flag, stores nothing.
- R3: A read of 0x44C returns the oldest record's byte count in bits [LEN_W-1:0], with the upper bits zero. It does not remove the record, so repeated reads return the same value.
- R4: A read of 0x450 returns the oldest record's ID in bits [ID_W-1:0], with the upper bits zero, and removes that record.
- R5: Records come out in the order in which they were accepted.
- R6: Bit 31 of 0x428 reads 1 while at least one record is stored, and reads 0 once the last record has been removed.
- R7: Every accepted end sets completion bit (ID mod DONE_W) in bits [DONE_W-1:0] of 0x428. Reading 0x428 clears the completion bits it returned. A bit set in the same cycle as that read is kept and shows on the next read.
- R8: A record and its completion bit become visible together, to a read strobed on the clock edge after the one that accepted the end.
- R9: When the queue holds DEPTH records and no record is removed in the same cycle, a new record is dropped, the stored records are unchanged, and bit 30 of 0x428 is set.
- R10: The overflow bit stays set until 0x428 is read. That read returns 1 and clears the bit, so the next read returns 0 unless another record was dropped in between.
- R11: A read of 0x44C or 0x450 while the queue is empty returns 0 and changes no state.
- R12: If a full queue removes a record in the same cycle that a new record arrives, the new record is stored and no overflow is flagged.
- R13: Read data appears in the cycle after `rdEn`. Any other address, and any cycle without a read, gives 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| endValid | input | 1 | A transfer end is reported this cycle |
| endId | input | ID_W | ID of the transfer that ended |
| endBytes | input | LEN_W | Bytes actually moved by the transfer |
| endPartial | input | 1 | The transfer ended before its programmed length |
| endReport | input | 1 | The transfer was submitted with the report request flag |
| rdEn | input | 1 | Register read strobe |
| rdAddr | input | ADDR_W | Byte offset of the register read |
| rdData | output | 32 | Read data, valid in the cycle after `rdEn` |

## Verification
The bench targets the following corner cases, each with the wrong behaviour it would expose:
- **Reading the count first.** A design that removes the record on the count read would return the following record's ID.
- **Empty reads.** A design that removes a record on an empty read would corrupt the pointers, and later records would come out wrong.
- **Full queue.** A design that overwrites the newest slot would show a changed last record, and one that skips the flag would read 0 in bit 30.
- **Remove and arrive in one cycle on a full queue.** A design that checks fullness before the removal would drop the new record and raise a false overflow.
- **End arriving during a completion-register read.** A design that clears the completion bits after the set would lose the new completion bit.

// File: rtl/xsr_pkg.sv
package xsr_pkg;

  localparam logic [31:0] XSR_OFS_DONE = 32'h0000_0428;
  localparam logic [31:0] XSR_OFS_LEN  = 32'h0000_044C;
  localparam logic [31:0] XSR_OFS_ID   = 32'h0000_0450;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_LEN  = 2'd1,
    SEL_ID   = 2'd2,
    SEL_DONE = 2'd3
  } xsr_sel_e;

  typedef struct packed {
    logic     push;
    logic     pop;
    xsr_sel_e sel;
  } xsr_strobe_t;

endpackage

// File: rtl/xsr_ctrl.sv
module xsr_ctrl
  import xsr_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int ID_W   = 5,
  parameter int DONE_W = 16,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              endValid,
  input  logic [ID_W-1:0]   endId,
  input  logic              endPartial,
  input  logic              endReport,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] rdAddr,
  output xsr_strobe_t       strb,
  output logic              notEmpty,
  output logic              ovfFlag,
  output logic [DONE_W-1:0] doneBits
);

  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [CNT_W-1:0]  count;
  logic              isFull;
  logic              hitLen;
  logic              hitId;
  logic              hitDone;
  logic              wantRec;
  logic              ovfSet;
  logic [DONE_W-1:0] setMask;

  assign isFull   = (count == FULL_CNT);
  assign notEmpty = (count != '0);

  always_comb begin
    hitLen  = rdEn && (rdAddr == XSR_OFS_LEN[ADDR_W-1:0]);
    hitId   = rdEn && (rdAddr == XSR_OFS_ID[ADDR_W-1:0]);
    hitDone = rdEn && (rdAddr == XSR_OFS_DONE[ADDR_W-1:0]);
    if (hitLen)       strb.sel = SEL_LEN;
    else if (hitId)   strb.sel = SEL_ID;
    else if (hitDone) strb.sel = SEL_DONE;
    else              strb.sel = SEL_NONE;
    strb.pop  = hitId && notEmpty;
    wantRec   = endValid && endPartial && endReport;
    strb.push = wantRec && (!isFull || strb.pop);
    ovfSet    = wantRec && isFull && !strb.pop;
  end

  always_comb begin
    for (int i = 0; i < DONE_W; i++) begin
      setMask[i] = endValid && ((int'(endId) % DONE_W) == i);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count    <= '0;
      ovfFlag  <= 1'b0;
      doneBits <= '0;
    end else begin
      count    <= count + CNT_W'(strb.push) - CNT_W'(strb.pop);
      ovfFlag  <= (ovfFlag && !hitDone) || ovfSet;
      doneBits <= (hitDone ? '0 : doneBits) | setMask;
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    count <= FULL_CNT); // R9
  AST_DROP_FLAGGED: assert property (@(posedge clk) disable iff (!rstN)
    (wantRec && isFull && !strb.pop) |=> (ovfFlag && count == FULL_CNT)); // R9
  AST_DONE_SET: assert property (@(posedge clk) disable iff (!rstN)
    endValid |=> (doneBits != '0)); // R7
  AST_REC_VISIBLE: assert property (@(posedge clk) disable iff (!rstN)
    strb.push |=> notEmpty); // R8
  AST_POP_SHRINKS: assert property (@(posedge clk) disable iff (!rstN)
    (strb.pop && !strb.push) |=> (count == $past(count) - 1'b1)); // R4

endmodule

// File: rtl/xsr_datapath.sv
module xsr_datapath
  import xsr_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int ID_W   = 5,
  parameter int LEN_W  = 24,
  parameter int DONE_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  xsr_strobe_t       strb,
  input  logic [ID_W-1:0]   endId,
  input  logic [LEN_W-1:0]  endBytes,
  input  logic              notEmpty,
  input  logic              ovfFlag,
  input  logic [DONE_W-1:0] doneBits,
  output logic [31:0]       rdData
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] LAST_SLOT = PTR_W'(DEPTH - 1);

  logic [ID_W-1:0]  idMem  [DEPTH];
  logic [LEN_W-1:0] lenMem [DEPTH];
  logic [PTR_W-1:0] wrPtr;
  logic [PTR_W-1:0] rdPtr;
  logic [31:0]      rdNext;

  function automatic logic [PTR_W-1:0] ptrInc(input logic [PTR_W-1:0] p);
    return (p == LAST_SLOT) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (strb.push) begin
      idMem[wrPtr]  <= endId;
      lenMem[wrPtr] <= endBytes;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (strb.push) wrPtr <= ptrInc(wrPtr);
      if (strb.pop)  rdPtr <= ptrInc(rdPtr);
    end
  end

  always_comb begin
    rdNext = '0;
    unique case (strb.sel)
      SEL_LEN:  if (notEmpty) rdNext = {{(32-LEN_W){1'b0}}, lenMem[rdPtr]};
      SEL_ID:   if (notEmpty) rdNext = {{(32-ID_W){1'b0}}, idMem[rdPtr]};
      SEL_DONE: rdNext = {notEmpty, ovfFlag, {(30-DONE_W){1'b0}}, doneBits};
      default:  rdNext = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) rdData <= '0;
    else       rdData <= rdNext;
  end

  AST_EMPTY_READ_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    ((strb.sel == SEL_ID || strb.sel == SEL_LEN) && !notEmpty) |=> (rdData == '0)); // R11
  AST_PTR_MATCH: assert property (@(posedge clk) disable iff (!rstN)
    !notEmpty |-> (wrPtr == rdPtr)); // R5
  AST_LEN_NO_POP: assert property (@(posedge clk) disable iff (!rstN)
    (strb.sel == SEL_LEN) |=> $stable(rdPtr)); // R3

endmodule

// File: rtl/xfer_short_report.sv
module xfer_short_report
  import xsr_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int ID_W   = 5,
  parameter int LEN_W  = 24,
  parameter int DONE_W = 16,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              endValid,
  input  logic [ID_W-1:0]   endId,
  input  logic [LEN_W-1:0]  endBytes,
  input  logic              endPartial,
  input  logic              endReport,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [31:0]       rdData
);

  xsr_strobe_t       strb;
  logic              notEmpty;
  logic              ovfFlag;
  logic [DONE_W-1:0] doneBits;

  xsr_ctrl #(
    .DEPTH(DEPTH), .ID_W(ID_W), .DONE_W(DONE_W), .ADDR_W(ADDR_W)
  ) ctrl_i (
    .clk(clk), .rstN(rstN),
    .endValid(endValid), .endId(endId),
    .endPartial(endPartial), .endReport(endReport),
    .rdEn(rdEn), .rdAddr(rdAddr),
    .strb(strb), .notEmpty(notEmpty), .ovfFlag(ovfFlag), .doneBits(doneBits)
  );

  xsr_datapath #(
    .DEPTH(DEPTH), .ID_W(ID_W), .LEN_W(LEN_W), .DONE_W(DONE_W)
  ) data_i (
    .clk(clk), .rstN(rstN), .strb(strb),
    .endId(endId), .endBytes(endBytes),
    .notEmpty(notEmpty), .ovfFlag(ovfFlag), .doneBits(doneBits),
    .rdData(rdData)
  );

endmodule

// File: tb/xfer_short_report_tb_top.sv
`timescale 1ns/1ps
module xfer_short_report_tb_top;

  localparam int DEPTH = 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        endValid = 1'b0;
  logic [4:0]  endId = '0;
  logic [23:0] endBytes = '0;
  logic        endPartial = 1'b0;
  logic        endReport = 1'b0;
  logic        rdEn = 1'b0;
  logic [11:0] rdAddr = '0;
  logic [31:0] rdData;

  int checks = 0;
  int fails = 0;

  typedef struct { logic [4:0] id; logic [23:0] len; } rec_t;
  rec_t        q[$];
  logic [15:0] expDone = '0;
  logic        expOvf = 1'b0;

  always #2.5 clk = ~clk;

  xfer_short_report #(.DEPTH(DEPTH)) dut_i (
    .clk(clk), .rstN(rstN),
    .endValid(endValid), .endId(endId), .endBytes(endBytes),
    .endPartial(endPartial), .endReport(endReport),
    .rdEn(rdEn), .rdAddr(rdAddr), .rdData(rdData)
  );

  task automatic compare(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // One clock: optional end event and optional read; the scoreboard model
  // predicts the read from the pre-edge state, then applies the edge.
  task automatic cycle(input bit doEnd, input int id, input int len,
                       input bit part, input bit rep,
                       input bit doRd, input logic [11:0] addr, input string tag);
    logic [31:0] exp;
    rec_t r;
    exp = '0;
    if (doRd) begin
      case (addr)
        12'h44C: if (q.size() != 0) exp = {8'h0, q[0].len};
        12'h450: if (q.size() != 0) exp = {27'h0, q[0].id};
        12'h428: exp = {(q.size() != 0), expOvf, 14'h0, expDone};
        default: exp = '0;
      endcase
    end
    endValid   = doEnd;
    endId      = 5'(id);
    endBytes   = 24'(len);
    endPartial = part;
    endReport  = rep;
    rdEn       = doRd;
    rdAddr     = addr;
    @(posedge clk);
    @(negedge clk);
    endValid = 1'b0; endPartial = 1'b0; endReport = 1'b0; rdEn = 1'b0;
    if (doRd && addr == 12'h450 && q.size() != 0) void'(q.pop_front());
    if (doRd && addr == 12'h428) begin expDone = '0; expOvf = 1'b0; end
    if (doEnd) begin
      expDone[id % 16] = 1'b1;
      if (part && rep) begin
        if (q.size() < DEPTH) begin
          r.id = 5'(id); r.len = 24'(len); q.push_back(r);
        end else expOvf = 1'b1;
      end
    end
    if (doRd) compare(rdData, exp, tag);
  endtask

  task automatic sendEnd(input int id, input int len, input bit part, input bit rep);
    cycle(1'b1, id, len, part, rep, 1'b0, 12'h000, "");
  endtask

  task automatic rd(input logic [11:0] addr, input string tag);
    cycle(1'b0, 0, 0, 1'b0, 1'b0, 1'b1, addr, tag);
  endtask

  task automatic drainAll(input string tag);
    while (q.size() != 0) begin
      rd(12'h44C, tag);
      rd(12'h450, tag);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL R13 watchdog actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    compare(rdData, 32'h0, "R1 rdData after reset");
    rd(12'h428, "R1 completion reg after reset");
    rd(12'h44C, "R1 count reg after reset");

    // R2: full-length end and unflagged short end make no record
    sendEnd(3, 100, 1'b0, 1'b1);
    sendEnd(4, 50, 1'b1, 1'b0);
    rd(12'h428, "R2 R7 completion bits, no summary");
    rd(12'h428, "R7 completion bits cleared by read");

    // R8: record and completion bit visible together on the next read
    sendEnd(7, 77, 1'b1, 1'b1);
    rd(12'h428, "R8 summary and completion bit together");
    rd(12'h44C, "R3 count peek");
    rd(12'h44C, "R3 count peek again, no removal");
    rd(12'h400, "R13 other address reads zero");
    rd(12'h450, "R4 ID read removes");
    rd(12'h428, "R6 summary clear after drain");

    // R5: order across several records, ID 31 maps to bit 15
    sendEnd(31, 24'hABCDEF, 1'b1, 1'b1);
    sendEnd(0, 1, 1'b1, 1'b1);
    sendEnd(12, 4096, 1'b1, 1'b1);
    sendEnd(5, 9, 1'b0, 1'b0);
    sendEnd(20, 300, 1'b1, 1'b1);
    rd(12'h428, "R7 ID 31 sets bit 15");
    rd(12'h44C, "R5 order head count");
    rd(12'h450, "R5 order head id");
    rd(12'h450, "R5 order second id");
    rd(12'h428, "R6 summary with records left");
    drainAll("R5 order drain");
    rd(12'h428, "R6 summary clear");

    // R9/R10: overflow
    for (int i = 0; i < DEPTH + 2; i++) sendEnd(10 + i, 1000 + i, 1'b1, 1'b1);
    rd(12'h428, "R9 overflow flag set");
    rd(12'h428, "R10 overflow cleared by read");
    drainAll("R9 stored records unchanged");

    // R11: empty reads have no effect
    rd(12'h450, "R11 empty ID read");
    rd(12'h44C, "R11 empty count read");
    rd(12'h428, "R11 no state change");
    sendEnd(9, 99, 1'b1, 1'b1);
    drainAll("R11 queue intact after empty reads");

    // R12: remove and arrive in one cycle on a full queue
    for (int i = 0; i < DEPTH; i++) sendEnd(i, 200 + i, 1'b1, 1'b1);
    cycle(1'b1, 25, 555, 1'b1, 1'b1, 1'b1, 12'h450, "R12 pop while full");
    rd(12'h428, "R12 no overflow on simultaneous pop");
    drainAll("R12 new record at tail");

    // R7: end in the same cycle as a completion read survives
    sendEnd(1, 5, 1'b0, 1'b0);
    cycle(1'b1, 2, 6, 1'b0, 1'b0, 1'b1, 12'h428, "R7 read while set");
    rd(12'h428, "R7 same-cycle set kept");

    summary();
    $finish;
  end

endmodule